// File: doc/BRIEF.md
# Flat Panel Sync and Line Clock Generator

This block turns the display-timing core's horizontal sync, vertical sync and vertical display-enable into the control strobes a flat panel needs. Each rising edge of the source horizontal sync launches one panel horizontal pulse. The launch can be delayed by a programmable number of master clocks, and the pulse width is programmable. When vertical retrace begins, the block adds a programmable burst of extra line-clock pulses at one of two fixed rates.

The panel line clock is the union of the horizontal pulses and the burst pulses. Every rising edge of the line clock is a line event. The panel vertical sync and the AC modulation output are both counted in line events. The vertical sync starts at the first line event after the source vertical sync rises, and its end can be pushed out by a programmable number of line events. The modulation output is a square wave whose half period is a programmable number of line events. Its phase runs freely across frames.

The polarity of each panel sync comes either from the block's own invert bits or from the global sync-polarity setting. A single select bit chooses the source. All configuration inputs are sampled live, and a burst latches its rate when it starts.

Top module: `fp_panel_timing`

## Requirements
- R1: While reset is held, and until the first pulse after it, the line clock and MOD outputs are 0, and each panel sync output equals its selected invert value (inactive level).
- R2: A rising edge of src_hsync, sampled at clock edge n, starts the panel horizontal pulse after clock edge n+S, where S is cfg_hs_skew (0 to 127 master clocks).
- R3: The panel horizontal pulse lasts (w+1)*8 master clocks, where w is cfg_hs_width.
- R4: A rising edge of src_hsync that arrives while a horizontal pulse is pending (in its skew delay) or active is ignored.
- R5: A falling edge of src_vde starts a retrace burst of cfg_burst_len pulses. When cfg_burst_fast is 0, the period is 32 master clocks and each pulse is high for the first 8. When it is 1, the period is 64 and each pulse is high for the first 16. A length of 0 produces no burst, and a falling edge during a running burst is ignored.
- R6: pnl_lclk is high whenever the horizontal pulse or a burst pulse is high. Each 0-to-1 transition of pnl_lclk is one line event.
- R7: After a rising edge of src_vsync, the panel vertical sync turns on one cycle after the next line event. It turns off one cycle after the line event numbered (1 + cfg_vs_wide + cfg_vs_delay) counted from the turn-on event. This covers 1 or 2 line events, plus 0 to 31 more.
- R8: With a nonzero half period H, pnl_mod toggles one cycle after every H-th line event. Frame boundaries never reset its phase, and it changes at no other time.
- R9: A half period of 0 drives pnl_mod low and restarts its count.
- R10: When cfg_pol_own is 1, pnl_hsync is inverted by cfg_hs_inv and pnl_vsync by cfg_vs_inv. When cfg_pol_own is 0, glb_hs_inv and glb_vs_inv invert them instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| src_hsync | input | 1 | Horizontal sync from the timing core, active high |
| src_vsync | input | 1 | Vertical sync from the timing core, active high |
| src_vde | input | 1 | Vertical display enable, low during retrace |
| cfg_hs_skew | input | 7 | Horizontal pulse delay in master clocks |
| cfg_hs_width | input | 2 | Horizontal width code w, width (w+1)*8 |
| cfg_vs_delay | input | 5 | Extra line events before vertical sync ends |
| cfg_vs_wide | input | 1 | Vertical sync base width of two line events |
| cfg_burst_len | input | 5 | Number of line-clock pulses in the retrace burst |
| cfg_burst_fast | input | 1 | Burst rate select, 64/16 when set, 32/8 when clear |
| cfg_mod_half | input | 8 | MOD half period in line events, 0 holds low |
| cfg_pol_own | input | 1 | Take sync polarity from the local invert bits |
| cfg_hs_inv | input | 1 | Local horizontal sync invert |
| cfg_vs_inv | input | 1 | Local vertical sync invert |
| glb_hs_inv | input | 1 | Global horizontal sync invert |
| glb_vs_inv | input | 1 | Global vertical sync invert |
| pnl_hsync | output | 1 | Panel horizontal sync |
| pnl_vsync | output | 1 | Panel vertical sync |
| pnl_lclk | output | 1 | Panel line clock |
| pnl_mod | output | 1 | AC modulation output |

## Verification
The stimulus is a stream of frames built from 200-cycle lines. Each frame uses a different mix of skew, width, burst length, burst rate, vertical delay and half period. Zero skew with no burst checks the plain path. Small skews with slow bursts make burst pulses merge with horizontal pulses, which shows that line events come from the combined line clock and not from each source on its own. The maximum skew with fast bursts and a 33-event vertical sync checks the counter limits and a vertical sync that crosses a frame boundary. A second source sync edge placed inside the skew delay, a zero half period, and a sweep of all polarity sources check that extra edges are ignored, that MOD is held low, and that polarity selection works. A half period that does not divide the frame length shows that the MOD phase carries from one frame into the next.

// File: rtl/fp_panel_pkg.sv
package fp_panel_pkg;

    localparam int SKEW_W      = 7;
    localparam int HSW_W       = 2;
    localparam int VDLY_W      = 5;
    localparam int BURST_W     = 5;
    localparam int MOD_W       = 8;
    localparam int SLOW_PERIOD = 32;
    localparam int SLOW_HIGH   = 8;
    localparam int PH_W        = $clog2(2 * SLOW_PERIOD);

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_SKEW   = 2'd1,
        HS_ACTIVE = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_pol_t;

    // last phase value of one burst period
    function automatic logic [PH_W-1:0] burst_last(input logic fast);
        return fast ? PH_W'(2 * SLOW_PERIOD - 1) : PH_W'(SLOW_PERIOD - 1);
    endfunction

    // number of high cycles at the start of a burst period
    function automatic logic [PH_W-1:0] burst_high(input logic fast);
        return fast ? PH_W'(2 * SLOW_HIGH) : PH_W'(SLOW_HIGH);
    endfunction

    function automatic sync_pol_t pick_pol(input logic own,
                                           input logic own_h, input logic own_v,
                                           input logic glb_h, input logic glb_v);
        sync_pol_t p;
        p.hs = own ? own_h : glb_h;
        p.vs = own ? own_v : glb_v;
        return p;
    endfunction

endpackage

// File: rtl/fp_hs_gen.sv
module fp_hs_gen
    import fp_panel_pkg::*;
#(
    parameter int SKEW_BITS = SKEW_W,
    parameter int WID_BITS  = HSW_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_hs,
    input  logic [SKEW_BITS-1:0] skew,
    input  logic [WID_BITS-1:0]  wid,
    output logic                 pulse
);
    localparam int LEN_W = WID_BITS + 3;
    localparam int CNT_W = (SKEW_BITS > LEN_W) ? SKEW_BITS : LEN_W;

    hs_state_e          st;
    logic               src_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   len_m1;

    // (w+1)*8 - 1 == w*8 + 7
    assign len_m1 = CNT_W'({wid, 3'b111});

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= HS_IDLE;
            src_q <= 1'b0;
            cnt   <= '0;
        end else begin
            src_q <= src_hs;
            case (st)
                HS_IDLE: begin
                    if (src_hs && !src_q) begin
                        if (skew == '0) begin
                            st  <= HS_ACTIVE;
                            cnt <= len_m1;
                        end else begin
                            st  <= HS_SKEW;
                            cnt <= CNT_W'(skew) - CNT_W'(1);
                        end
                    end
                end
                HS_SKEW: begin
                    if (cnt == '0) begin
                        st  <= HS_ACTIVE;
                        cnt <= len_m1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                HS_ACTIVE: begin
                    if (cnt == '0) st <= HS_IDLE;
                    else           cnt <= cnt - CNT_W'(1);
                end
                default: st <= HS_IDLE;
            endcase
        end
    end

    assign pulse = (st == HS_ACTIVE);

endmodule

// File: rtl/fp_burst_gen.sv
module fp_burst_gen
    import fp_panel_pkg::*;
#(
    parameter int LEN_BITS = BURST_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                src_vde,
    input  logic [LEN_BITS-1:0] count,
    input  logic                fast,
    output logic                pulse
);
    logic                vde_q;
    logic                run;
    logic                fast_l;
    logic [PH_W-1:0]     ph;
    logic [LEN_BITS-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            vde_q  <= 1'b0;
            run    <= 1'b0;
            fast_l <= 1'b0;
            ph     <= '0;
            left   <= '0;
        end else begin
            vde_q <= src_vde;
            if (!run) begin
                if (!src_vde && vde_q && count != '0) begin
                    run    <= 1'b1;
                    ph     <= '0;
                    left   <= count;
                    fast_l <= fast;
                end
            end else if (ph == burst_last(fast_l)) begin
                ph <= '0;
                if (left == LEN_BITS'(1)) run  <= 1'b0;
                else                      left <= left - LEN_BITS'(1);
            end else begin
                ph <= ph + PH_W'(1);
            end
        end
    end

    assign pulse = run && (ph < burst_high(fast_l));

endmodule

// File: rtl/fp_vs_gen.sv
module fp_vs_gen
    import fp_panel_pkg::*;
#(
    parameter int DLY_BITS = VDLY_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                src_vs,
    input  logic                line_evt,
    input  logic [DLY_BITS-1:0] delay,
    input  logic                wide,
    output logic                active
);
    localparam int LEFT_W = DLY_BITS + 1;

    logic              vs_q;
    logic              pend;
    logic [LEFT_W-1:0] left;
    logic [LEFT_W-1:0] len_m1;

    // (1 + wide + delay) events in total, minus the starting one
    assign len_m1 = LEFT_W'(delay) + LEFT_W'(wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q   <= 1'b0;
            pend   <= 1'b0;
            active <= 1'b0;
            left   <= '0;
        end else begin
            vs_q <= src_vs;
            if (line_evt) begin
                if (active) begin
                    if (left == '0) active <= 1'b0;
                    else            left   <= left - LEFT_W'(1);
                end else if (pend) begin
                    active <= 1'b1;
                    left   <= len_m1;
                    pend   <= 1'b0;
                end
            end
            if (src_vs && !vs_q) pend <= 1'b1;
        end
    end

endmodule

// File: rtl/fp_mod_gen.sv
module fp_mod_gen
    import fp_panel_pkg::*;
#(
    parameter int HALF_BITS = MOD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_evt,
    input  logic [HALF_BITS-1:0] half,
    output logic                 mod
);
    logic [HALF_BITS-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mod <= 1'b0;
        end else if (half == '0) begin
            cnt <= '0;
            mod <= 1'b0;
        end else if (line_evt) begin
            if (cnt >= half - HALF_BITS'(1)) begin
                cnt <= '0;
                mod <= ~mod;
            end else begin
                cnt <= cnt + HALF_BITS'(1);
            end
        end
    end

endmodule

// File: rtl/fp_panel_timing.sv
module fp_panel_timing
    import fp_panel_pkg::*;
#(
    parameter int SKEW_BITS  = SKEW_W,
    parameter int WID_BITS   = HSW_W,
    parameter int DLY_BITS   = VDLY_W,
    parameter int BURST_BITS = BURST_W,
    parameter int HALF_BITS  = MOD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  src_hsync,
    input  logic                  src_vsync,
    input  logic                  src_vde,
    input  logic [SKEW_BITS-1:0]  cfg_hs_skew,
    input  logic [WID_BITS-1:0]   cfg_hs_width,
    input  logic [DLY_BITS-1:0]   cfg_vs_delay,
    input  logic                  cfg_vs_wide,
    input  logic [BURST_BITS-1:0] cfg_burst_len,
    input  logic                  cfg_burst_fast,
    input  logic [HALF_BITS-1:0]  cfg_mod_half,
    input  logic                  cfg_pol_own,
    input  logic                  cfg_hs_inv,
    input  logic                  cfg_vs_inv,
    input  logic                  glb_hs_inv,
    input  logic                  glb_vs_inv,
    output logic                  pnl_hsync,
    output logic                  pnl_vsync,
    output logic                  pnl_lclk,
    output logic                  pnl_mod
);
    logic      hs_lvl;
    logic      burst_lvl;
    logic      lclk_lvl;
    logic      lclk_d;
    logic      line_evt;
    logic      vs_lvl;
    sync_pol_t pol;

    fp_hs_gen #(.SKEW_BITS(SKEW_BITS), .WID_BITS(WID_BITS)) u_hs (
        .clk(clk), .rst(rst), .src_hs(src_hsync),
        .skew(cfg_hs_skew), .wid(cfg_hs_width), .pulse(hs_lvl)
    );

    fp_burst_gen #(.LEN_BITS(BURST_BITS)) u_burst (
        .clk(clk), .rst(rst), .src_vde(src_vde),
        .count(cfg_burst_len), .fast(cfg_burst_fast), .pulse(burst_lvl)
    );

    assign lclk_lvl = hs_lvl | burst_lvl;

    always_ff @(posedge clk) begin
        if (rst) lclk_d <= 1'b0;
        else     lclk_d <= lclk_lvl;
    end

    assign line_evt = lclk_lvl & ~lclk_d;

    fp_vs_gen #(.DLY_BITS(DLY_BITS)) u_vs (
        .clk(clk), .rst(rst), .src_vs(src_vsync), .line_evt(line_evt),
        .delay(cfg_vs_delay), .wide(cfg_vs_wide), .active(vs_lvl)
    );

    fp_mod_gen #(.HALF_BITS(HALF_BITS)) u_mod (
        .clk(clk), .rst(rst), .line_evt(line_evt),
        .half(cfg_mod_half), .mod(pnl_mod)
    );

    always_comb pol = pick_pol(cfg_pol_own, cfg_hs_inv, cfg_vs_inv, glb_hs_inv, glb_vs_inv);

    assign pnl_hsync = hs_lvl ^ pol.hs;
    assign pnl_vsync = vs_lvl ^ pol.vs;
    assign pnl_lclk  = lclk_lvl;

endmodule

// File: rtl/fp_panel_timing_chk.sv
module fp_panel_timing_chk
    import fp_panel_pkg::*;
#(
    parameter int WID_BITS  = HSW_W,
    parameter int HALF_BITS = MOD_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 hs_lvl,
    input logic                 vs_lvl,
    input logic                 line_evt,
    input logic [HALF_BITS-1:0] mod_half,
    input logic                 mod_o
);
    localparam int MAX_HS = 1 << (WID_BITS + 3);
    localparam int RUN_W  = WID_BITS + 5;

    logic [RUN_W-1:0] hs_run;

    always_ff @(posedge clk) begin
        if (rst)                          hs_run <= '0;
        else if (!hs_lvl)                 hs_run <= '0;
        else if (hs_run != {RUN_W{1'b1}}) hs_run <= hs_run + RUN_W'(1);
    end

    // R3
    hs_width_bound_chk: assert property (@(posedge clk) disable iff (rst)
        hs_run <= RUN_W'(MAX_HS));

    // R7
    vs_moves_on_line_chk: assert property (@(posedge clk) disable iff (rst)
        !line_evt |=> $stable(vs_lvl));

    // R8
    mod_moves_on_line_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_evt && mod_half != '0) |=> $stable(mod_o));

    // R9
    mod_zero_half_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_half == '0) |=> !mod_o);

endmodule

bind fp_panel_timing fp_panel_timing_chk #(
    .WID_BITS(WID_BITS), .HALF_BITS(HALF_BITS)
) u_chk (
    .clk(clk), .rst(rst), .hs_lvl(hs_lvl), .vs_lvl(vs_lvl),
    .line_evt(line_evt), .mod_half(cfg_mod_half), .mod_o(pnl_mod)
);

// File: tb/fp_panel_timing_tb.sv
module fp_panel_timing_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_hsync = 1'b0, src_vsync = 1'b0, src_vde = 1'b1;
    logic [6:0] cfg_hs_skew = '0;
    logic [1:0] cfg_hs_width = '0;
    logic [4:0] cfg_vs_delay = '0;
    logic       cfg_vs_wide = 1'b0;
    logic [4:0] cfg_burst_len = '0;
    logic       cfg_burst_fast = 1'b0;
    logic [7:0] cfg_mod_half = '0;
    logic       cfg_pol_own = 1'b0, cfg_hs_inv = 1'b0, cfg_vs_inv = 1'b0;
    logic       glb_hs_inv = 1'b0, glb_vs_inv = 1'b0;
    logic       pnl_hsync, pnl_vsync, pnl_lclk, pnl_mod;

    always #5 clk = ~clk;

    fp_panel_timing u_dut (
        .clk(clk), .rst(rst), .src_hsync(src_hsync), .src_vsync(src_vsync),
        .src_vde(src_vde), .cfg_hs_skew(cfg_hs_skew), .cfg_hs_width(cfg_hs_width),
        .cfg_vs_delay(cfg_vs_delay), .cfg_vs_wide(cfg_vs_wide),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_fast(cfg_burst_fast),
        .cfg_mod_half(cfg_mod_half), .cfg_pol_own(cfg_pol_own),
        .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
        .glb_hs_inv(glb_hs_inv), .glb_vs_inv(glb_vs_inv),
        .pnl_hsync(pnl_hsync), .pnl_vsync(pnl_vsync),
        .pnl_lclk(pnl_lclk), .pnl_mod(pnl_mod)
    );

    int errs = 0, checks = 0, cyc = 0, mod_toggles = 0;
    bit done = 1'b0;

    // behavioural reference state (timestamps and counters)
    int  hs_start, hs_end, b_start, b_end, b_per, b_hi;
    int  vs_left, mc;
    bit  p_hs, p_vde, p_vs, m_hs, m_b, l_prev, evt, vs_on, vs_pend, m_mod;

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            p_hs = 0; p_vde = 0; p_vs = 0; m_hs = 0; m_b = 0; l_prev = 0; evt = 0;
            hs_start = -1; hs_end = -1; b_start = -1; b_end = -1; b_per = 32; b_hi = 8;
            vs_on = 0; vs_pend = 0; vs_left = 0; mc = 0; m_mod = 0;
        end else begin
            // line-event driven outputs use the event seen before this edge
            if (evt) begin
                if (vs_on) begin
                    if (vs_left == 0) vs_on = 0; else vs_left--;
                end else if (vs_pend) begin
                    vs_on = 1; vs_pend = 0;
                    vs_left = int'(cfg_vs_wide) + int'(cfg_vs_delay);
                end
            end
            if (src_vsync && !p_vs) vs_pend = 1;
            p_vs = src_vsync;
            if (cfg_mod_half == 0) begin
                m_mod = 0; mc = 0;
            end else if (evt) begin
                mc++;
                if (mc >= int'(cfg_mod_half)) begin mc = 0; m_mod = !m_mod; end
            end
            // horizontal pulse
            if (src_hsync && !p_hs && cyc > hs_end) begin
                hs_start = cyc + int'(cfg_hs_skew);
                hs_end   = hs_start + (int'(cfg_hs_width) + 1) * 8;
            end
            p_hs = src_hsync;
            m_hs = (cyc >= hs_start) && (cyc < hs_end);
            // retrace burst
            if (!src_vde && p_vde && cyc > b_end && cfg_burst_len != 0) begin
                b_start = cyc;
                b_per = cfg_burst_fast ? 64 : 32;
                b_hi  = cfg_burst_fast ? 16 : 8;
                b_end = cyc + int'(cfg_burst_len) * b_per;
            end
            p_vde = src_vde;
            m_b = (cyc >= b_start) && (cyc < b_end) && (((cyc - b_start) % b_per) < b_hi);
            evt = (m_hs || m_b) && !l_prev;
            l_prev = m_hs || m_b;
        end
    end

    logic last_mod = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R3 R4 R10 hsync", pnl_hsync,
                m_hs ^ (cfg_pol_own ? cfg_hs_inv : glb_hs_inv));
            chk("R5 R6 lclk", pnl_lclk, m_hs | m_b);
            chk("R7 R10 vsync", pnl_vsync,
                vs_on ^ (cfg_pol_own ? cfg_vs_inv : glb_vs_inv));
            chk("R8 R9 mod", pnl_mod, m_mod);
            if (pnl_mod !== last_mod) mod_toggles++;
            last_mod = pnl_mod;
        end
    end

    task automatic line(input bit vde, input bit vs);
        src_vde = vde; src_vsync = vs; src_hsync = 1'b1;
        repeat (16) @(negedge clk);
        src_hsync = 1'b0;
        repeat (184) @(negedge clk);
    endtask

    task automatic frame(input int n, input int ret, input int vsl);
        for (int i = 0; i < n; i++) line(i < ret, i == vsl);
    endtask

    // second source edge lands inside the skew window
    task automatic double_line();
        src_vde = 1'b1; src_vsync = 1'b0;
        src_hsync = 1'b1; repeat (4) @(negedge clk);
        src_hsync = 1'b0; repeat (6) @(negedge clk);
        src_hsync = 1'b1; repeat (4) @(negedge clk);
        src_hsync = 1'b0; repeat (186) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            errs++; checks++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        glb_hs_inv = 1'b1;
        repeat (4) @(negedge clk);
        // R1: inactive levels under reset (global hsync invert selected)
        chk("R1 hsync", pnl_hsync, 1'b1);
        chk("R1 vsync", pnl_vsync, 1'b0);
        chk("R1 lclk", pnl_lclk, 1'b0);
        chk("R1 mod", pnl_mod, 1'b0);
        glb_hs_inv = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 hsync after reset", pnl_hsync, 1'b0);

        // R2 R3 R5 (empty burst) R7 R8: plain path
        cfg_mod_half = 8'd3;
        frame(12, 9, 10);

        // R5 slow burst merging with horizontal pulses, R7 wide plus delay
        cfg_hs_skew = 7'd5; cfg_hs_width = 2'd3;
        cfg_burst_len = 5'd3; cfg_burst_fast = 1'b0;
        cfg_vs_wide = 1'b1; cfg_vs_delay = 5'd2; cfg_mod_half = 8'd7;
        frame(12, 8, 9);
        frame(12, 8, 9);

        // R2 maximum skew, R5 fast burst, R7 longest vertical sync
        cfg_hs_skew = 7'd127; cfg_hs_width = 2'd2;
        cfg_burst_len = 5'd2; cfg_burst_fast = 1'b1;
        cfg_vs_delay = 5'd31; cfg_mod_half = 8'd5;
        frame(40, 30, 31);

        // R4 extra source edge during skew
        cfg_hs_skew = 7'd40; cfg_hs_width = 2'd1;
        for (int i = 0; i < 5; i++) double_line();

        // R9 zero half period, then R8 resumes with free-running phase
        cfg_mod_half = 8'd0;
        frame(12, 9, 10);
        cfg_mod_half = 8'd5;
        frame(13, 10, 11);
        frame(13, 10, 11);
        checks++;
        if (mod_toggles == 0) begin
            errs++;
            $display("FAIL R8: got %0d toggles expected nonzero", mod_toggles);
        end

        // R10 polarity source sweep
        cfg_vs_delay = 5'd0; cfg_vs_wide = 1'b0;
        cfg_pol_own = 1'b1; cfg_hs_inv = 1'b1; cfg_vs_inv = 1'b0;
        glb_hs_inv = 1'b0; glb_vs_inv = 1'b1;
        frame(10, 7, 8);
        cfg_hs_inv = 1'b0; cfg_vs_inv = 1'b1;
        frame(10, 7, 8);
        cfg_pol_own = 1'b0; glb_hs_inv = 1'b1; glb_vs_inv = 1'b0;
        frame(10, 7, 8);

        finish_run();
    end

endmodule